// File: doc/BRIEF.md
# Stacked Combo Memory Chip-Select Router

This block sits between a host and a package that stacks two 16-bit flash dies and one pseudo-static RAM on shared address, data and write-enable lines. The host presents one request at a time over a valid/ready handshake. Each request carries a region (flash or RAM), a word address, a read/write flag, a burst flag with a word count, and the low byte of the write data. The router turns each request into a sequence of one-cycle beats. In each beat it drives the strobes of exactly one device and the in-device word address.

The flash region covers 8M words. The top address bit chooses the die, and the next four bits give the bank within that die. The router enforces the package rules. Only one device is enabled at a time, and every access starts after a cycle in which all enables are off. A two-cycle flash command must finish on the die where it began. Bursts never run past a device's address limit: a burst that reaches the end of a device is closed and restarted as a fresh access. The router also drives the shared flash reset and the RAM sleep pin. It holds a sticky error with a code until the host clears it.

Top module: `combo_cs_router`

## Requirements
- R1: A flash request with address bit 22 low enables die 1 (`f_ce_n[0]`); with bit 22 high it enables die 2 (`f_ce_n[1]`). `mem_addr` carries address bits 21:0 in every beat.
- R2: During a flash beat, `bank_idx` equals address bits 22:18, so it runs 0–15 on die 1 and 16–31 on die 2. It is 0 during RAM beats.
- R3: At most one of `f_ce_n[0]`, `f_ce_n[1]` and `ram_ce_n` is low in any cycle. An output enable is low only together with the chip enable of the same device.
- R4: A read beat drives the device's CE and OE low with `we_n` high. A write beat drives the device's CE and `we_n` low with every OE high.
- R5: A flash write whose data byte is a setup code (0x40 or 0x20) opens a command pair. If the next flash write decodes to the other die, it is refused: it produces no beat, the pair closes, and error code 1 is raised. A second write to the same die is carried out normally.
- R6: A burst whose next word would cross a device limit (address bits 21:0 all ones) is split. One cycle with all enables high follows, then the burst continues on the die the next address decodes to, with `addr_strobe` high. Address 0x7FFFFF wraps to 0 on die 1.
- R7: `f_rst_n` is low during `rst_n` low. Otherwise it equals the inverse of `flash_reset` one cycle later, and it resets both dies together. Asserting `flash_reset` also discards an open command pair.
- R8: `ram_zz_n` follows the inverse of `ram_sleep` one cycle later, but it does not change while a RAM access is under way. While it is low, `ram_ce_n` stays high. A RAM request made while it is low is refused with error code 3.
- R9: A read burst with nonzero `req_len` gives `req_len` beats at consecutive addresses. Any other request gives one beat. `req_ready` is low from the cycle after acceptance until the last beat has ended.
- R10: Every access, including the second half of a split burst, begins with `addr_strobe` high in a cycle directly after one in which all chip enables were high.
- R11: Region codes 2 and 3 are refused with error code 2. `err` and `err_code` keep the first error until `err_clr`. An error raised in the same cycle as `err_clr` is kept.
- R12: Out of reset, `req_ready` is high, all chip and output enables are high, and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can take a request |
| req_region | input | 2 | 0 flash, 1 RAM, 2–3 illegal |
| req_addr | input | 23 | Word address |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | Burst read |
| req_len | input | 4 | Burst word count |
| req_wbyte | input | 8 | Low byte of write data, for command decode |
| flash_reset | input | 1 | Request reset of both flash dies |
| ram_sleep | input | 1 | Request RAM deep sleep |
| err_clr | input | 1 | Clear the sticky error |
| f_ce_n | output | 2 | Flash chip enables, one per die |
| f_oe_n | output | 2 | Flash output enables, one per die |
| we_n | output | 1 | Shared write enable |
| ram_ce_n | output | 1 | RAM chip enable |
| ram_oe_n | output | 1 | RAM output enable |
| ram_zz_n | output | 1 | RAM sleep pin |
| f_rst_n | output | 1 | Shared flash reset |
| mem_addr | output | 22 | In-device word address |
| addr_strobe | output | 1 | First beat of an access |
| bank_idx | output | 5 | Global flash bank of the current beat |
| err | output | 1 | Sticky error flag |
| err_code | output | 2 | 1 straddled pair, 2 bad region, 3 RAM asleep |

## Verification
The hardest case to reach is the burst split. It happens only when a read burst's address runs onto the last word of a device, so the stimulus places short bursts at 0x3FFFFE and 0x7FFFFF and at the top of the RAM range. The scoreboard expects the gap cycle and the fresh strobe on the far side of each split. The straddled command pair needs a setup write followed by a write to the other die. The bench issues this pair and then a matching pair on a single die, so both outcomes are seen. The sleep interlock is exercised by raising sleep before a RAM request and checking the refusal.

// File: rtl/combo_cs_router.sv
module combo_cs_router #(
  parameter int ADDR_W     = 23,
  parameter int LEN_W      = 4,
  parameter int BANK_OFF_W = 18,
  parameter logic [7:0] CMD_A = 8'h40,
  parameter logic [7:0] CMD_B = 8'h20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_region,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic                      req_burst,
  input  logic [LEN_W-1:0]          req_len,
  input  logic [7:0]                req_wbyte,
  input  logic                      flash_reset,
  input  logic                      ram_sleep,
  input  logic                      err_clr,
  output logic [1:0]                f_ce_n,
  output logic [1:0]                f_oe_n,
  output logic                      we_n,
  output logic                      ram_ce_n,
  output logic                      ram_oe_n,
  output logic                      ram_zz_n,
  output logic                      f_rst_n,
  output logic [ADDR_W-2:0]         mem_addr,
  output logic                      addr_strobe,
  output logic [ADDR_W-BANK_OFF_W-1:0] bank_idx,
  output logic                      err,
  output logic [1:0]                err_code
);
  localparam int BANK_W = ADDR_W - BANK_OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;
  typedef enum logic [1:0] {DV_F1, DV_F2, DV_RAM} dev_t;

  st_t               st;
  dev_t              dev;
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  left;
  logic              wr, first;
  logic              pend_v, pend_die;
  logic              zz_n_q, frst_q;

  logic is_flash, is_ram, bad_reg, rdie, setup, straddle, asleep, refuse, acc, ram_busy, in_run, at_edge;
  logic [1:0]        new_code;
  logic [LEN_W-1:0]  beats;
  logic [ADDR_W-1:0] nxt;

  assign req_ready = (st == S_IDLE);
  assign acc       = req_valid && req_ready;
  assign is_flash  = (req_region == 2'd0);
  assign is_ram    = (req_region == 2'd1);
  assign bad_reg   = req_region[1];
  assign rdie      = req_addr[ADDR_W-1];
  assign setup     = (req_wbyte == CMD_A) || (req_wbyte == CMD_B);
  assign straddle  = is_flash && req_write && pend_v && (rdie != pend_die);
  assign asleep    = is_ram && !zz_n_q;
  assign refuse    = bad_reg || straddle || asleep;
  assign new_code  = bad_reg ? 2'd2 : (straddle ? 2'd1 : 2'd3);
  assign beats     = (req_burst && !req_write && req_len != '0) ? req_len : LEN_W'(1);
  assign nxt       = cur + 1'b1;
  assign at_edge   = &cur[ADDR_W-2:0];
  assign ram_busy  = (st != S_IDLE && dev == DV_RAM) || (acc && is_ram);
  assign in_run    = (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dev <= DV_F1; cur <= '0; left <= '0; wr <= 1'b0; first <= 1'b0;
      pend_v <= 1'b0; pend_die <= 1'b0; err <= 1'b0; err_code <= 2'd0;
      zz_n_q <= 1'b1; frst_q <= 1'b0;
    end else begin
      frst_q <= !flash_reset;
      if (!ram_busy) zz_n_q <= !ram_sleep;
      if (err_clr) begin
        err <= 1'b0; err_code <= 2'd0;
      end
      if (acc && refuse && (!err || err_clr)) begin
        err <= 1'b1; err_code <= new_code;
      end
      case (st)
        S_IDLE: if (acc) begin
          if (straddle) pend_v <= 1'b0;
          if (!refuse) begin
            st    <= S_RUN;
            dev   <= is_ram ? DV_RAM : (rdie ? DV_F2 : DV_F1);
            cur   <= req_addr;
            left  <= beats;
            wr    <= req_write;
            first <= 1'b1;
            if (is_flash && req_write) begin
              if (pend_v) pend_v <= 1'b0;
              else if (setup) begin
                pend_v <= 1'b1; pend_die <= rdie;
              end
            end
          end
        end
        S_RUN: begin
          first <= 1'b0;
          if (left == LEN_W'(1)) st <= S_IDLE;
          else begin
            left <= left - 1'b1;
            cur  <= nxt;
            if (at_edge) begin
              st    <= S_GAP;
              first <= 1'b1;
              if (dev != DV_RAM) dev <= nxt[ADDR_W-1] ? DV_F2 : DV_F1;
            end
          end
        end
        default: st <= S_RUN;
      endcase
      if (flash_reset) pend_v <= 1'b0;
    end
  end

  assign f_ce_n[0]   = !(in_run && dev == DV_F1);
  assign f_ce_n[1]   = !(in_run && dev == DV_F2);
  assign f_oe_n[0]   = !(in_run && dev == DV_F1 && !wr);
  assign f_oe_n[1]   = !(in_run && dev == DV_F2 && !wr);
  assign ram_ce_n    = !(in_run && dev == DV_RAM);
  assign ram_oe_n    = !(in_run && dev == DV_RAM && !wr);
  assign we_n        = !(in_run && wr);
  assign ram_zz_n    = zz_n_q;
  assign f_rst_n     = frst_q;
  assign mem_addr    = cur[ADDR_W-2:0];
  assign addr_strobe = in_run && first;
  assign bank_idx    = (in_run && dev != DV_RAM) ? cur[ADDR_W-1:BANK_OFF_W] : BANK_W'(0);
endmodule

// File: rtl/combo_cs_router_chk.sv
module combo_cs_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] f_ce_n,
  input logic [1:0] f_oe_n,
  input logic       we_n,
  input logic       ram_ce_n,
  input logic       ram_oe_n,
  input logic       ram_zz_n,
  input logic       f_rst_n,
  input logic       flash_reset,
  input logic       addr_strobe
);
  logic all_off;
  assign all_off = (&f_ce_n) && ram_ce_n;

  a_r3_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({f_ce_n, ram_ce_n}) >= 2);
  a_r3_oe_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    ((~f_oe_n & f_ce_n) == 2'b00) && (ram_oe_n || !ram_ce_n));
  a_r4_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> ((&f_oe_n) && ram_oe_n));
  a_r10_gap_f1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_ce_n[0]) |-> $past(all_off));
  a_r10_gap_f2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_ce_n[1]) |-> $past(all_off));
  a_r10_gap_ram: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ce_n) |-> $past(all_off));
  a_r6_fresh_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(all_off) |-> addr_strobe);
  a_r8_sleep_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_zz_n |-> ram_ce_n);
  a_r7_flash_rst: assert property (@(posedge clk) disable iff (!rst_n)
    flash_reset |=> !f_rst_n);
endmodule

bind combo_cs_router combo_cs_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .we_n(we_n),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_zz_n(ram_zz_n),
  .f_rst_n(f_rst_n), .flash_reset(flash_reset), .addr_strobe(addr_strobe)
);

// File: tb/combo_cs_router_test.sv
module combo_cs_router_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_burst = 0;
  logic [1:0] req_region = 0;
  logic [22:0] req_addr = 0;
  logic [3:0] req_len = 0;
  logic [7:0] req_wbyte = 0;
  logic flash_reset = 0, ram_sleep = 0, err_clr = 0;
  logic req_ready, we_n, ram_ce_n, ram_oe_n, ram_zz_n, f_rst_n, addr_strobe, err;
  logic [1:0] f_ce_n, f_oe_n, err_code;
  logic [21:0] mem_addr;
  logic [4:0] bank_idx;

  always #4 clk = ~clk;

  combo_cs_router uut (.*);

  typedef struct packed {logic [1:0] dev; logic [22:0] a; logic wr; logic first;} beat_t;
  beat_t exp_q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit prev_on = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor: pops one expected beat per enabled cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      logic [1:0] od;
      n = 0; od = 0;
      if (!f_ce_n[0]) begin n++; od = 0; end
      if (!f_ce_n[1]) begin n++; od = 1; end
      if (!ram_ce_n)  begin n++; od = 2; end
      if (n > 1) chk(0, "R3 enables", n, 1);
      if (n == 1) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected beat", mem_addr, 0);
        else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(od == e.dev, "R1 device", od, e.dev);
          chk(mem_addr == e.a[21:0], "R1 address", mem_addr, e.a[21:0]);
          chk(addr_strobe == e.first, "R6 strobe", addr_strobe, e.first);
          if (e.wr) chk(!we_n && (&f_oe_n) && ram_oe_n, "R4 write strobes", {we_n, f_oe_n, ram_oe_n}, 4'b0111);
          else chk(we_n && (od == 2 ? !ram_oe_n : !f_oe_n[od]), "R4 read strobes", {we_n, f_oe_n, ram_oe_n}, od);
          chk(bank_idx == (od == 2 ? 5'd0 : e.a[22:18]), "R2 bank", bank_idx, od == 2 ? 5'd0 : e.a[22:18]);
          if (e.first) chk(!prev_on, "R10 idle before access", prev_on, 0);
        end
      end
      prev_on = (n != 0);
    end
  end

  task automatic req(input logic [1:0] reg_, input logic [22:0] a, input logic w, input logic b,
                     input logic [3:0] len, input logic [7:0] wb, input logic [1:0] exp_code);
    int nb;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_region = reg_; req_addr = a; req_write = w; req_burst = b; req_len = len; req_wbyte = wb;
    if (exp_code == 0) begin
      nb = (b && !w && len != 0) ? len : 1;
      for (int i = 0; i < nb; i++) begin
        logic [22:0] cur, prv;
        beat_t e;
        cur = a + 23'(i);
        prv = cur - 1'b1;
        e.dev = (reg_ == 2'd1) ? 2'd2 : {1'b0, cur[22]};
        e.a = cur; e.wr = w;
        e.first = (i == 0) || (&prv[21:0]);
        exp_q.push_back(e);
      end
    end
    @(negedge clk);
    req_valid = 0;
    if (exp_code != 0) chk(err && err_code == exp_code, "R5/R8/R11 error code", {err, err_code}, {1'b1, exp_code});
    else chk(!req_ready, "R9 ready low during access", req_ready, 0);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic clear_err;
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    chk(!err && err_code == 0, "R11 clear", {err, err_code}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready, "R12 ready", req_ready, 1);
    chk((&f_ce_n) && ram_ce_n && (&f_oe_n) && ram_oe_n, "R12 enables", {f_ce_n, ram_ce_n}, 3'b111);
    chk(!err, "R12 err", err, 0);
    chk(!f_rst_n, "R7 flash reset in reset", f_rst_n, 0);
    rst_n = 1;
    @(negedge clk);
    chk(f_rst_n, "R7 flash reset released", f_rst_n, 1);

    req(2'd0, 23'h000123, 0, 0, 0, 8'h00, 0);   // R1 die 1
    req(2'd0, 23'h6C0001, 0, 0, 0, 8'h00, 0);   // R1 R2 die 2 bank 27
    req(2'd0, 23'h000200, 1, 0, 0, 8'h12, 0);   // R4 write
    req(2'd0, 23'h000100, 0, 1, 3, 8'h00, 0);   // R9 burst 3
    req(2'd0, 23'h3FFFFE, 0, 1, 4, 8'h00, 0);   // R6 split across dies
    req(2'd0, 23'h000300, 1, 1, 5, 8'h00, 0);   // R9 write burst is one beat
    req(2'd1, 23'h000010, 0, 1, 2, 8'h00, 0);   // RAM read burst
    req(2'd1, 23'h000020, 1, 0, 0, 8'h00, 0);   // RAM write
    req(2'd0, 23'h7FFFFF, 0, 1, 2, 8'h00, 0);   // R6 wrap to die 1
    req(2'd1, 23'h3FFFFF, 0, 1, 2, 8'h00, 0);   // R6 RAM limit restart

    // R5 straddled pair
    req(2'd0, 23'h000010, 1, 0, 0, 8'h40, 0);
    req(2'd0, 23'h400010, 1, 0, 0, 8'h55, 2'd1);
    clear_err();
    // R5 pair on one die is accepted
    req(2'd0, 23'h400010, 1, 0, 0, 8'h20, 0);
    req(2'd0, 23'h400011, 1, 0, 0, 8'hD0, 0);
    chk(!err, "R5 same-die pair no error", err, 0);

    // R11 bad region, sticky against a later error
    req(2'd2, 23'h000000, 0, 0, 0, 8'h00, 2'd2);
    ram_sleep = 1;
    @(negedge clk); @(negedge clk);
    chk(!ram_zz_n && ram_ce_n, "R8 sleep pin", {ram_zz_n, ram_ce_n}, 2'b01);
    req(2'd1, 23'h000005, 0, 0, 0, 8'h00, 2'd2);  // R11 code stays 2
    clear_err();
    req(2'd1, 23'h000005, 0, 0, 0, 8'h00, 2'd3);  // R8 refused asleep
    ram_sleep = 0;
    @(negedge clk); @(negedge clk);
    chk(ram_zz_n, "R8 wake", ram_zz_n, 1);

    // R11 error in the same cycle as clear is kept
    @(negedge clk);
    err_clr = 1; req_valid = 1; req_region = 2'd3;
    @(negedge clk);
    err_clr = 0; req_valid = 0; req_region = 0;
    chk(err && err_code == 2'd2, "R11 error beats clear", {err, err_code}, 3'b110);
    clear_err();

    // R7 shared flash reset, also drops an open pair
    req(2'd0, 23'h000040, 1, 0, 0, 8'h40, 0);
    @(negedge clk); flash_reset = 1;
    @(negedge clk);
    chk(!f_rst_n, "R7 reset both dies", f_rst_n, 0);
    flash_reset = 0;
    @(negedge clk);
    chk(f_rst_n, "R7 reset released", f_rst_n, 1);
    req(2'd0, 23'h400040, 1, 0, 0, 8'h11, 0);
    chk(!err, "R7 pair discarded by reset", err, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all beats seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule